// File: doc/BRIEF.md
# Burst Write Request Segmenter

This block takes memory-mapped burst writes made of 64-bit (qword) beats and turns each burst into one or more write packet requests for a packetized transmit path. Each packet begins with one header beat. The header carries the start byte address, the length in dwords, the byte enables of the first and last dwords, and a flag that says whether the address is in the 32-bit or the 64-bit form. The payload qwords follow the header in the order they arrived.

A packet is cut where the address reaches a 4 KB boundary. It is also cut when it reaches the maximum payload size selected on a configuration input. The address translation step is reduced to a fixed upper address word and an enable for the 64-bit form. Both are sampled when the burst is accepted.

The block also watches the byte enables of each beat. It raises a one-cycle error pulse for any beat whose enable pattern does not fit a single contiguous run across the burst.

Top module: `burst_wr_segmenter`

## Requirements
- R1: While reset is held and after it is released, `m_valid` is 0, `s_waitrequest` is 1 and `proto_err` is 0 until a burst is presented.
- R2: The first packet address is the burst start, plus 4 when the low dword of the first beat has no enables. `m_hdr_fbe` holds the enables of the first enabled dword: bits 3:0 of a beat belong to its lower dword, and bits 7:4 belong to its upper dword.
- R3: No packet runs past a 4 KB address boundary. A burst that crosses one is cut exactly at that boundary, and the next header carries the boundary address.
- R4: The maximum payload is selected by `cfg_mps`: 00 selects 128 bytes, 01 selects 256 bytes, and 10 or 11 selects 512 bytes. Each packet holds at most that many bytes. Each later packet starts at the previous packet address plus the bytes already sent.
- R5: `m_hdr_len` is twice the packet's qword count, minus one for a disabled low dword at the start and minus one for a disabled high dword at the end. `m_hdr_lbe` holds the enables of the last dword, and it is 0 for a one-dword packet.
- R6: When `cfg_addr64_en` is 1 and `cfg_upper_addr` is non-zero, `m_hdr_is64` is 1 and address bits 63:32 equal `cfg_upper_addr`. In every other case `m_hdr_is64` is 0 and those address bits are 0.
- R7: `s_waitrequest` is 1 while no burst is in progress, while a header beat is pending, and while `m_ready` is 0. Payload qwords leave in order, with none lost and none duplicated. `m_eop` marks the last qword of each packet.
- R8: `proto_err` pulses one cycle after an accepted beat breaks the enable rules. The rules are: a first beat must be non-zero; in a multi-beat burst, the first beat must be a run of ones reaching bit 7, every middle beat must be all ones, and the last beat must be a run of ones starting at bit 0 that equals `s_tail_be`. A burst that follows the rules never raises the pulse.
- R9: A header beat that is stalled by `m_ready` low stays valid, and its fields do not change, until it is taken.
- R10: A change of `cfg_mps` after a burst has been accepted has no effect on how that burst is cut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mps | input | 2 | Maximum payload select |
| cfg_upper_addr | input | 32 | Upper address word used for the 64-bit form |
| cfg_addr64_en | input | 1 | Permits the 64-bit address form |
| s_write | input | 1 | Write beat present |
| s_qaddr | input | 29 | Burst start as a qword address (byte address bits 31:3) |
| s_burstcount | input | 7 | Beats in the burst, 1 to 64 |
| s_writedata | input | 64 | Beat data |
| s_byteenable | input | 8 | Beat byte enables |
| s_tail_be | input | 8 | Byte enables of the burst's last beat, held with the first beat |
| s_waitrequest | output | 1 | Stalls the sender |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream accepts a beat |
| m_sop | output | 1 | Beat is a packet header |
| m_eop | output | 1 | Last payload qword of a packet |
| m_data | output | 64 | Payload qword |
| m_be | output | 8 | Payload byte enables |
| m_hdr_addr | output | 64 | Packet byte address |
| m_hdr_len | output | 8 | Packet length in dwords |
| m_hdr_fbe | output | 4 | First dword byte enables |
| m_hdr_lbe | output | 4 | Last dword byte enables |
| m_hdr_is64 | output | 1 | 64-bit address form |
| proto_err | output | 1 | Byte-enable rule violation pulse |

## Verification
The bench uses the package defaults: a 4 KB boundary and a 64-beat maximum burst. With these values, a burst near the end of a 4 KB page produces a two-packet cut. The 128-byte and 256-byte payload limits each split a long burst into several packets, and the 512-byte limit lets a full burst go out as one packet. Random-free, periodic back-pressure on `m_ready` exercises stalls of headers and of payload beats. The partial-enable cases, the one-dword case and the malformed enable patterns are each driven in their own directed scenario.

// File: rtl/bws_pkg.sv
package bws_pkg;

    localparam int DATA_W      = 64;
    localparam int BE_W        = DATA_W / 8;
    localparam int ADDR_W      = 32;
    localparam int QADDR_W     = ADDR_W - 3;
    localparam int BOUND_BYTES = 4096;
    localparam int BOUND_W     = $clog2(BOUND_BYTES);
    localparam int MAX_BEATS   = 64;
    localparam int CNT_W       = $clog2(MAX_BEATS + 1);
    localparam int LEN_W       = $clog2(2 * MAX_BEATS + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA
    } seg_state_t;

    typedef struct packed {
        logic [2*ADDR_W-1:0] addr;
        logic [LEN_W-1:0]    len;
        logic [3:0]          fbe;
        logic [3:0]          lbe;
        logic                is64;
    } pkt_hdr_t;

    function automatic logic [CNT_W-1:0] mps_to_beats(input logic [1:0] code);
        case (code)
            2'b00:   return CNT_W'(128 / BE_W);
            2'b01:   return CNT_W'(256 / BE_W);
            default: return CNT_W'(512 / BE_W);
        endcase
    endfunction

    // ones from some bit up to the top bit (all-ones allowed)
    function automatic logic is_high_run(input logic [BE_W-1:0] be);
        logic [BE_W-1:0] inv;
        inv = ~be;
        return (inv & (inv + 1'b1)) == '0;
    endfunction

    // ones from bit zero up to some bit (all-ones allowed)
    function automatic logic is_low_run(input logic [BE_W-1:0] be);
        return (be & (be + 1'b1)) == '0;
    endfunction

endpackage

// File: rtl/bws_hdr_calc.sv
module bws_hdr_calc
    import bws_pkg::*;
(
    input  logic [QADDR_W-1:0] qaddr,
    input  logic [CNT_W-1:0]   rem,
    input  logic [CNT_W-1:0]   mps_beats,
    input  logic               first_beat,
    input  logic [BE_W-1:0]    head_be,
    input  logic [BE_W-1:0]    tail_be,
    input  logic [ADDR_W-1:0]  upper,
    input  logic               en64,
    output pkt_hdr_t           hdr,
    output logic [CNT_W-1:0]   seg_beats
);
    localparam int QW_BOUND = BOUND_BYTES / BE_W;
    localparam int TB_W     = BOUND_W - 2;

    logic [TB_W-1:0]  to_bound;
    logic [CNT_W-1:0] lim;
    logic [BE_W-1:0]  first_q, last_q;
    logic             lo_skip, hi_skip;

    always_comb begin
        to_bound  = TB_W'(QW_BOUND) - TB_W'(qaddr[BOUND_W-4:0]);
        lim       = (rem < mps_beats) ? rem : mps_beats;
        seg_beats = (TB_W'(lim) > to_bound) ? CNT_W'(to_bound) : lim;

        first_q = first_beat ? head_be : ((rem == CNT_W'(1)) ? tail_be : '1);
        last_q  = (seg_beats == CNT_W'(1)) ? first_q
                : ((seg_beats == rem) ? tail_be : '1);
        lo_skip = (first_q[3:0] == 4'h0);
        hi_skip = (last_q[7:4] == 4'h0);

        hdr.len  = LEN_W'({seg_beats, 1'b0}) - LEN_W'(lo_skip) - LEN_W'(hi_skip);
        hdr.is64 = en64 && (upper != '0);
        hdr.addr = {hdr.is64 ? upper : '0, qaddr, lo_skip, 2'b00};
        hdr.fbe  = lo_skip ? first_q[7:4] : first_q[3:0];
        hdr.lbe  = (hdr.len == LEN_W'(1)) ? 4'h0
                 : (hi_skip ? last_q[3:0] : last_q[7:4]);
    end

endmodule

// File: rtl/bws_be_check.sv
module bws_be_check
    import bws_pkg::*;
(
    input  logic [BE_W-1:0] be,
    input  logic            is_first,
    input  logic            is_last,
    input  logic            multi,
    input  logic [BE_W-1:0] tail_be,
    output logic            bad
);
    always_comb begin
        if (is_first)
            bad = (be == '0) || (multi && !is_high_run(be));
        else if (is_last)
            bad = (be == '0) || (be != tail_be) || !is_low_run(be);
        else
            bad = (be != '1);
    end

endmodule

// File: rtl/burst_wr_segmenter.sv
module burst_wr_segmenter
    import bws_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          cfg_mps,
    input  logic [ADDR_W-1:0]   cfg_upper_addr,
    input  logic                cfg_addr64_en,
    input  logic                s_write,
    input  logic [QADDR_W-1:0]  s_qaddr,
    input  logic [CNT_W-1:0]    s_burstcount,
    input  logic [DATA_W-1:0]   s_writedata,
    input  logic [BE_W-1:0]     s_byteenable,
    input  logic [BE_W-1:0]     s_tail_be,
    output logic                s_waitrequest,
    output logic                m_valid,
    input  logic                m_ready,
    output logic                m_sop,
    output logic                m_eop,
    output logic [DATA_W-1:0]   m_data,
    output logic [BE_W-1:0]     m_be,
    output logic [2*ADDR_W-1:0] m_hdr_addr,
    output logic [LEN_W-1:0]    m_hdr_len,
    output logic [3:0]          m_hdr_fbe,
    output logic [3:0]          m_hdr_lbe,
    output logic                m_hdr_is64,
    output logic                proto_err
);
    seg_state_t          state;
    logic [QADDR_W-1:0]  qaddr_q;
    logic [CNT_W-1:0]    rem_q, seg_left_q, mps_q;
    logic                first_q, multi_q, en64_q;
    logic [BE_W-1:0]     head_be_q, tail_be_q;
    logic [ADDR_W-1:0]   upper_q;

    pkt_hdr_t            hdr;
    logic [CNT_W-1:0]    seg_beats;
    logic                be_bad;
    logic                accept;

    bws_hdr_calc u_hdr (
        .qaddr      (qaddr_q),
        .rem        (rem_q),
        .mps_beats  (mps_q),
        .first_beat (first_q),
        .head_be    (head_be_q),
        .tail_be    (tail_be_q),
        .upper      (upper_q),
        .en64       (en64_q),
        .hdr        (hdr),
        .seg_beats  (seg_beats)
    );

    bws_be_check u_be (
        .be       (s_byteenable),
        .is_first (first_q),
        .is_last  (rem_q == CNT_W'(1)),
        .multi    (multi_q),
        .tail_be  (tail_be_q),
        .bad      (be_bad)
    );

    assign accept        = (state == ST_DATA) && s_write && m_ready;
    assign s_waitrequest = !((state == ST_DATA) && m_ready);
    assign m_valid       = (state == ST_HDR) || ((state == ST_DATA) && s_write);
    assign m_sop         = (state == ST_HDR);
    assign m_eop         = (state == ST_DATA) && (seg_left_q == CNT_W'(1));
    assign m_data        = s_writedata;
    assign m_be          = s_byteenable;
    assign m_hdr_addr    = hdr.addr;
    assign m_hdr_len     = hdr.len;
    assign m_hdr_fbe     = hdr.fbe;
    assign m_hdr_lbe     = hdr.lbe;
    assign m_hdr_is64    = hdr.is64;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            qaddr_q    <= '0;
            rem_q      <= '0;
            seg_left_q <= '0;
            mps_q      <= '0;
            first_q    <= 1'b0;
            multi_q    <= 1'b0;
            en64_q     <= 1'b0;
            head_be_q  <= '0;
            tail_be_q  <= '0;
            upper_q    <= '0;
            proto_err  <= 1'b0;
        end else begin
            proto_err <= accept && be_bad;
            case (state)
                ST_IDLE: begin
                    if (s_write) begin
                        qaddr_q   <= s_qaddr;
                        rem_q     <= s_burstcount;
                        mps_q     <= mps_to_beats(cfg_mps);
                        first_q   <= 1'b1;
                        multi_q   <= (s_burstcount > CNT_W'(1));
                        head_be_q <= s_byteenable;
                        tail_be_q <= s_tail_be;
                        upper_q   <= cfg_upper_addr;
                        en64_q    <= cfg_addr64_en;
                        state     <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (m_ready) begin
                        seg_left_q <= seg_beats;
                        state      <= ST_DATA;
                    end
                end
                default: begin
                    if (accept) begin
                        qaddr_q    <= qaddr_q + 1'b1;
                        rem_q      <= rem_q - 1'b1;
                        seg_left_q <= seg_left_q - 1'b1;
                        first_q    <= 1'b0;
                        if (seg_left_q == CNT_W'(1))
                            state <= (rem_q == CNT_W'(1)) ? ST_IDLE : ST_HDR;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/bws_checker.sv
module bws_checker
    import bws_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                s_write,
    input logic                s_waitrequest,
    input logic                m_valid,
    input logic                m_ready,
    input logic                m_sop,
    input logic [2*ADDR_W-1:0] m_hdr_addr,
    input logic [LEN_W-1:0]    m_hdr_len,
    input logic [3:0]          m_hdr_lbe,
    input logic                m_hdr_is64,
    input logic                proto_err
);
    logic [BOUND_W+1:0] end_off;
    assign end_off = (BOUND_W+2)'(m_hdr_addr[BOUND_W-1:0]) + (BOUND_W+2)'({m_hdr_len, 2'b00});

    assert_hdr_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_sop) |-> s_waitrequest);

    assert_no_cross_R3: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_sop) |-> (end_off <= (BOUND_W+2)'(BOUND_BYTES)));

    assert_len_cap_R4: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_sop) |-> (m_hdr_len != '0 && m_hdr_len <= LEN_W'(2 * MAX_BEATS)));

    assert_single_lbe_R5: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_sop && m_hdr_len == LEN_W'(1)) |-> (m_hdr_lbe == 4'h0));

    assert_addr_form_R6: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_sop) |-> (m_hdr_is64 == (m_hdr_addr[2*ADDR_W-1:ADDR_W] != '0)));

    assert_err_after_beat_R8: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> $past(s_write && !s_waitrequest));

    assert_hdr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_sop && !m_ready) |=>
            (m_valid && m_sop && $stable(m_hdr_addr) && $stable(m_hdr_len)));

endmodule

bind burst_wr_segmenter bws_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .s_write       (s_write),
    .s_waitrequest (s_waitrequest),
    .m_valid       (m_valid),
    .m_ready       (m_ready),
    .m_sop         (m_sop),
    .m_hdr_addr    (m_hdr_addr),
    .m_hdr_len     (m_hdr_len),
    .m_hdr_lbe     (m_hdr_lbe),
    .m_hdr_is64    (m_hdr_is64),
    .proto_err     (proto_err)
);

// File: tb/burst_wr_segmenter_tb.sv
`timescale 1ns/1ps
module burst_wr_segmenter_tb;
    import bws_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] cfg_mps = 2'b10;
    logic [31:0] cfg_upper_addr = '0;
    logic cfg_addr64_en = 1'b0;
    logic s_write = 1'b0;
    logic [28:0] s_qaddr = '0;
    logic [6:0] s_burstcount = '0;
    logic [63:0] s_writedata = '0;
    logic [7:0] s_byteenable = '0;
    logic [7:0] s_tail_be = '0;
    logic s_waitrequest, m_valid, m_sop, m_eop, m_hdr_is64, proto_err;
    logic m_ready = 1'b1;
    logic [63:0] m_data, m_hdr_addr;
    logic [7:0] m_be, m_hdr_len;
    logic [3:0] m_hdr_fbe, m_hdr_lbe;

    always #2.5 clk = ~clk;

    burst_wr_segmenter u_dut (.*);

    int n_chk = 0, n_fail = 0;
    int hn, rx_n, rx_bad, eop_n, err_n, hold_bad, first_wait;
    logic [7:0] cur_tag;
    logic [63:0] h_addr [16];
    logic [7:0]  h_len  [16];
    logic [3:0]  h_fbe  [16];
    logic [3:0]  h_lbe  [16];
    logic        h_is64 [16];
    bit bp_on = 0;
    int bp_cnt = 0;
    bit prev_stall = 0;
    logic [71:0] prev_hdr;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic hchk(input string req, input int i, input logic [63:0] a,
                        input logic [7:0] l, input logic [3:0] f, input logic [3:0] lb,
                        input logic w);
        check(req, $sformatf("hdr%0d addr", i), h_addr[i], a);
        check(req, $sformatf("hdr%0d len/fbe/lbe/is64", i),
              {43'h0, h_len[i], h_fbe[i], h_lbe[i], h_is64[i]}, {43'h0, l, f, lb, w});
    endtask

    // back-pressure generator
    always @(posedge clk) begin
        #1;
        bp_cnt++;
        m_ready = bp_on ? ((bp_cnt % 3) != 0) : 1'b1;
    end

    // output monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall &&
                (!(m_valid && m_sop) || {m_hdr_addr, m_hdr_len} != prev_hdr))
                hold_bad++;
            prev_stall = m_valid && m_sop && !m_ready;
            prev_hdr   = {m_hdr_addr, m_hdr_len};
            if (m_valid && m_ready) begin
                if (m_sop) begin
                    if (hn < 16) begin
                        h_addr[hn] = m_hdr_addr; h_len[hn] = m_hdr_len;
                        h_fbe[hn] = m_hdr_fbe; h_lbe[hn] = m_hdr_lbe; h_is64[hn] = m_hdr_is64;
                    end
                    hn++;
                end else begin
                    if (m_data !== {24'hC0DE00, cur_tag, 32'(rx_n)}) rx_bad++;
                    rx_n++;
                    if (m_eop) eop_n++;
                end
            end
            if (proto_err) err_n++;
        end
    end

    task automatic do_burst(input logic [31:0] addr, input int cnt, input logic [7:0] head,
                            input logic [7:0] mid, input logic [7:0] tail,
                            input logic [7:0] tag, input bit flip);
        logic w;
        hn = 0; rx_n = 0; rx_bad = 0; eop_n = 0; err_n = 0; hold_bad = 0; first_wait = 0;
        cur_tag = tag;
        @(posedge clk);
        for (int i = 0; i < cnt; i++) begin
            #1;
            s_write      = 1'b1;
            s_qaddr      = addr[31:3];
            s_burstcount = 7'(cnt);
            s_tail_be    = tail;
            s_writedata  = {24'hC0DE00, tag, 32'(i)};
            s_byteenable = (i == 0) ? head : ((i == cnt - 1) ? tail : mid);
            if (flip && i == 1) cfg_mps = 2'b10;
            do begin
                @(negedge clk);
                w = s_waitrequest;
                if (i == 0 && w) first_wait = 1;
                @(posedge clk);
            end while (w);
        end
        #1 s_write = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1", "m_valid/waitreq/proto_err in reset",
              {61'h0, m_valid, s_waitrequest, proto_err}, 64'b010);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", "idle after reset",
              {61'h0, m_valid, s_waitrequest, proto_err}, 64'b010);
    endtask

    task automatic t_single_pkt;
        cfg_mps = 2'b10;
        do_burst(32'h1000, 4, 8'hFF, 8'hFF, 8'hFF, 8'h01, 0);
        check("R7", "stall before header", 64'(first_wait), 64'd1);
        check("R2", "packet count", 64'(hn), 64'd1);
        hchk("R2", 0, 64'h1000, 8'd8, 4'hF, 4'hF, 1'b0);
        check("R7", "data beats / mismatches / eops", {32'(rx_n), 16'(rx_bad), 16'(eop_n)},
              {32'd4, 16'd0, 16'd1});
        check("R8", "no error on legal burst", 64'(err_n), 64'd0);
    endtask

    task automatic t_boundary;
        cfg_mps = 2'b10;
        do_burst(32'h0FF0, 6, 8'hFF, 8'hFF, 8'hFF, 8'h02, 0);
        check("R3", "packet count", 64'(hn), 64'd2);
        hchk("R3", 0, 64'h0FF0, 8'd4, 4'hF, 4'hF, 1'b0);
        hchk("R3", 1, 64'h1000, 8'd8, 4'hF, 4'hF, 1'b0);
        check("R7", "beats / mismatches / eops", {32'(rx_n), 16'(rx_bad), 16'(eop_n)},
              {32'd6, 16'd0, 16'd2});
    endtask

    task automatic t_mps_128_bp;
        cfg_mps = 2'b00;
        bp_on = 1;
        do_burst(32'h2000, 40, 8'hFF, 8'hFF, 8'hFF, 8'h03, 1);
        bp_on = 0;
        check("R4", "packet count (R10 mid-burst change ignored)", 64'(hn), 64'd3);
        hchk("R4", 0, 64'h2000, 8'd32, 4'hF, 4'hF, 1'b0);
        hchk("R4", 1, 64'h2080, 8'd32, 4'hF, 4'hF, 1'b0);
        hchk("R10", 2, 64'h2100, 8'd16, 4'hF, 4'hF, 1'b0);
        check("R7", "beats / mismatches / eops under back-pressure",
              {32'(rx_n), 16'(rx_bad), 16'(eop_n)}, {32'd40, 16'd0, 16'd3});
        check("R9", "stalled header changes", 64'(hold_bad), 64'd0);
    endtask

    task automatic t_mps_256;
        cfg_mps = 2'b01;
        do_burst(32'h6000, 33, 8'hFF, 8'hFF, 8'hFF, 8'h04, 0);
        check("R4", "packet count at 256 bytes", 64'(hn), 64'd2);
        hchk("R4", 0, 64'h6000, 8'd64, 4'hF, 4'hF, 1'b0);
        hchk("R4", 1, 64'h6100, 8'd2, 4'hF, 4'hF, 1'b0);
    endtask

    task automatic t_partial;
        cfg_mps = 2'b10;
        do_burst(32'h3000, 3, 8'hF0, 8'hFF, 8'h03, 8'h05, 0);
        hchk("R2", 0, 64'h3004, 8'd4, 4'hF, 4'h3, 1'b0);
        check("R8", "no error on legal partial enables", 64'(err_n), 64'd0);
        do_burst(32'h4000, 1, 8'h0F, 8'hFF, 8'h00, 8'h06, 0);
        hchk("R5", 0, 64'h4000, 8'd1, 4'hF, 4'h0, 1'b0);
        check("R8", "no error on single beat", 64'(err_n), 64'd0);
    endtask

    task automatic t_addr_form;
        cfg_mps = 2'b10;
        cfg_upper_addr = 32'h0000_0001;
        cfg_addr64_en = 1'b1;
        do_burst(32'h5000, 2, 8'hFF, 8'hFF, 8'hFF, 8'h07, 0);
        hchk("R6", 0, 64'h1_0000_5000, 8'd4, 4'hF, 4'hF, 1'b1);
        cfg_addr64_en = 1'b0;
        do_burst(32'h5000, 2, 8'hFF, 8'hFF, 8'hFF, 8'h08, 0);
        hchk("R6", 0, 64'h5000, 8'd4, 4'hF, 4'hF, 1'b0);
        cfg_upper_addr = '0;
    endtask

    task automatic t_be_errors;
        cfg_mps = 2'b10;
        do_burst(32'h7000, 3, 8'hFF, 8'hFE, 8'hFF, 8'h09, 0);
        check("R8", "middle beat gap", 64'(err_n), 64'd1);
        do_burst(32'h7100, 2, 8'h0F, 8'hFF, 8'hFF, 8'h0A, 0);
        check("R8", "first beat not a high run", 64'(err_n), 64'd1);
        do_burst(32'h7200, 2, 8'hFF, 8'hFF, 8'h0D, 8'h0B, 0);
        check("R8", "last beat not a low run", 64'(err_n), 64'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_single_pkt();
        t_boundary();
        t_mps_128_bp();
        t_mps_256();
        t_partial();
        t_addr_form();
        t_be_errors();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule